// File: doc/BRIEF.md
# Dual-Section Timer with Variable-Width PWM

This block is a 16-bit counting unit built from a low and a high 8-bit section. A 2-bit mode field chooses how the sections are used: two independent 8-bit interval timers, an 8-bit interval timer beside an 8-bit pulse-width modulator, one 16-bit interval timer, or a pulse-width modulator whose period is 2^N ticks with N programmable from 9 to 16. Each section has its own sticky event flag, and the modulated waveform leaves on one output pin.

Counting advances only on tick enables supplied by the clock system. One enable marks each instruction cycle. The other fires twice as often. The narrow modes always count the instruction-cycle enable. The two wide modes can be switched to the faster enable for finer resolution. Software reaches the block through a small write port with four addresses.

A three-state sequencer governs counting. In HALT the counters stay at zero and the output is low. Setting the run bit moves HALT to ARM. ARM lasts one clock: it clears the counters, loads the duty buffer and latches the configuration. It then moves to RUN. From RUN, clearing the run bit returns to HALT, and any change to mode, resolution or width goes back to ARM so that counting restarts cleanly.

Top module: `pwm_timer_unit`

## Requirements
- R1: After reset, the output and both flags are low, all registers hold zero and the sequencer is in HALT.
- R2: A write is taken at the clock edge where wr_en is high. Address 0 is control: bits [1:0] mode, bit 2 fine resolution, bits [5:3] width select (N = 9 + value), bit 6 run. Address 1 is the low section value and address 2 the high section value. A write to address 3 clears the low flag if bit 0 is set and the high flag if bit 1 is set.
- R3: In mode 0, each section counts from 0 to its own value V and wraps, setting its own flag on the tick that completes each V+1-tick interval.
- R4: In mode 1, the low section behaves as in R3. The high section runs a 256-tick PWM period with the high value as duty, and its flag is set on the last tick of each period.
- R5: In mode 2, the pair counts to {high,low} and sets the high flag every {high,low}+1 ticks. The low flag is never set.
- R6: In mode 3, the period is 2^N ticks and the output is high while the 16-bit count is below the buffered {high,low} duty, so a duty of 2^N or more keeps it high. The high flag is set at each period end and the low flag is never set.
- R7: Modes 0 and 1 count only cyc_tick. Modes 2 and 3 count half_tick when fine resolution is set and cyc_tick otherwise. The unselected enable has no effect.
- R8: A new duty value takes effect only at the start of the next period or when the sequencer arms.
- R9: A duty of zero gives a constant low output. The output is low in modes 0 and 2 and whenever the sequencer is not in RUN.
- R10: Clearing the run bit in RUN moves to HALT. Changing mode, resolution or width in RUN moves through ARM, which restarts the counters from zero.
- R11: Flags stay set until cleared by a write. An event in the same cycle as a clear leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_tick | input | 1 | One-clock enable, once per instruction cycle |
| half_tick | input | 1 | One-clock enable, once per half instruction cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 8 | Write data |
| pwm_out | output | 1 | Modulated waveform |
| irq_lo | output | 1 | Low-section event flag |
| irq_hi | output | 1 | High-section event flag |

## Verification
The bench measures the interval to each flag at extreme values: a period value of zero, a value of 255, a 16-bit compare, and the 9-bit and 10-bit wide periods. An off-by-one wrap would show up as a shifted tick count. It drives the unselected tick enable in each mode; a design with the enable selection wrong would count when it should not, or miss ticks. It also changes the duty in the middle of a period and counts high ticks on both sides of the boundary, which exposes a design that loads the duty at once instead of waiting for the next period. A configuration change while running must restart the count, and a saturated duty in the wide mode must keep the output high for the whole period.

// File: rtl/pwt_pkg.sv
package pwt_pkg;

    typedef enum logic [1:0] {
        MODE_DUAL8   = 2'd0,
        MODE_T8_PWM8 = 2'd1,
        MODE_T16     = 2'd2,
        MODE_PWMV    = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        ST_HALT = 2'd0,
        ST_ARM  = 2'd1,
        ST_RUN  = 2'd2
    } seq_state_e;

    typedef struct packed {
        mode_e      mode;
        logic       fine;
        logic [2:0] wsel;
    } cfg_t;

    localparam int unsigned ADDR_CTRL = 0;
    localparam int unsigned ADDR_LO   = 1;
    localparam int unsigned ADDR_HI   = 2;
    localparam int unsigned ADDR_CLR  = 3;

endpackage

// File: rtl/pwt_regs.sv
module pwt_regs
    import pwt_pkg::*;
#(
    parameter int SEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [SEC_W-1:0] wr_data,
    input  logic             lo_evt,
    input  logic             hi_evt,
    output cfg_t             cfg,
    output logic             run,
    output logic [SEC_W-1:0] val_lo,
    output logic [SEC_W-1:0] val_hi,
    output logic             irq_lo,
    output logic             irq_hi
);

    logic wr_ctrl, wr_lo, wr_hi, wr_clr;

    always_comb begin
        wr_ctrl = wr_en && (wr_addr == 2'(ADDR_CTRL));
        wr_lo   = wr_en && (wr_addr == 2'(ADDR_LO));
        wr_hi   = wr_en && (wr_addr == 2'(ADDR_HI));
        wr_clr  = wr_en && (wr_addr == 2'(ADDR_CLR));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg    <= '{mode: MODE_DUAL8, fine: 1'b0, wsel: 3'd0};
            run    <= 1'b0;
            val_lo <= '0;
            val_hi <= '0;
        end else begin
            if (wr_ctrl) begin
                cfg.mode <= mode_e'(wr_data[1:0]);
                cfg.fine <= wr_data[2];
                cfg.wsel <= wr_data[5:3];
                run      <= wr_data[6];
            end
            if (wr_lo) val_lo <= wr_data;
            if (wr_hi) val_hi <= wr_data;
        end
    end

    // Sticky flags: an event outranks a clear in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_lo <= 1'b0;
            irq_hi <= 1'b0;
        end else begin
            irq_lo <= lo_evt || (irq_lo && !(wr_clr && wr_data[0]));
            irq_hi <= hi_evt || (irq_hi && !(wr_clr && wr_data[1]));
        end
    end

endmodule

// File: rtl/pwt_seq.sv
module pwt_seq
    import pwt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  cfg_t       cfg,
    input  logic       cyc_tick,
    input  logic       half_tick,
    output seq_state_e state,
    output cfg_t       act_cfg,
    output logic       clr_cnt,
    output logic       arm,
    output logic       tick_en
);

    seq_state_e state_nx;
    logic       wide_mode;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HALT;
        else        state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_HALT: if (run) state_nx = ST_ARM;
            ST_ARM:  state_nx = ST_RUN;
            ST_RUN: begin
                if (!run)                state_nx = ST_HALT;
                else if (cfg != act_cfg) state_nx = ST_ARM;
            end
            default: state_nx = ST_HALT;
        endcase
    end

    // Configuration is frozen while running
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              act_cfg <= '{mode: MODE_DUAL8, fine: 1'b0, wsel: 3'd0};
        else if (state == ST_ARM) act_cfg <= cfg;
    end

    // Outputs
    always_comb begin
        wide_mode = (act_cfg.mode == MODE_T16) || (act_cfg.mode == MODE_PWMV);
        clr_cnt   = 1'b1;
        arm       = 1'b0;
        tick_en   = 1'b0;
        unique case (state)
            ST_HALT: clr_cnt = 1'b1;
            ST_ARM: begin
                clr_cnt = 1'b1;
                arm     = 1'b1;
            end
            ST_RUN: begin
                clr_cnt = 1'b0;
                tick_en = (wide_mode && act_cfg.fine) ? half_tick : cyc_tick;
            end
            default: clr_cnt = 1'b1;
        endcase
    end

endmodule

// File: rtl/pwt_count.sv
module pwt_count
    import pwt_pkg::*;
#(
    parameter int SEC_W  = 8,
    parameter int WSEL_W = 3,
    parameter int MIN_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              tick_en,
    input  mode_e             mode,
    input  logic [WSEL_W-1:0] wsel,
    input  logic [SEC_W-1:0]  val_lo,
    input  logic [SEC_W-1:0]  val_hi,
    output logic [SEC_W-1:0]  cnt_lo,
    output logic [SEC_W-1:0]  cnt_hi,
    output logic              lo_evt,
    output logic              hi_evt
);

    localparam int CNT_W = 2 * SEC_W;

    logic [CNT_W-1:0] full_cnt;
    logic [CNT_W-1:0] full_val;
    logic [CNT_W-1:0] wrap_mask;
    logic [CNT_W:0]   pow_n;
    logic             lo_match, hi_match, full_match, wide_wrap;

    always_comb begin
        full_cnt   = {cnt_hi, cnt_lo};
        full_val   = {val_hi, val_lo};
        pow_n      = (CNT_W+1)'(1) << (MIN_W + int'(wsel));
        wrap_mask  = CNT_W'(pow_n - 1'b1);
        lo_match   = (cnt_lo == val_lo);
        hi_match   = (cnt_hi == val_hi);
        full_match = (full_cnt == full_val);
        wide_wrap  = ((full_cnt & wrap_mask) == wrap_mask);
    end

    always_comb begin
        lo_evt = 1'b0;
        hi_evt = 1'b0;
        unique case (mode)
            MODE_DUAL8: begin
                lo_evt = tick_en && lo_match;
                hi_evt = tick_en && hi_match;
            end
            MODE_T8_PWM8: begin
                lo_evt = tick_en && lo_match;
                hi_evt = tick_en && (&cnt_hi);
            end
            MODE_T16:  hi_evt = tick_en && full_match;
            MODE_PWMV: hi_evt = tick_en && wide_wrap;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_lo <= '0;
            cnt_hi <= '0;
        end else if (clr) begin
            cnt_lo <= '0;
            cnt_hi <= '0;
        end else if (tick_en) begin
            unique case (mode)
                MODE_DUAL8: begin
                    cnt_lo <= lo_match ? '0 : cnt_lo + 1'b1;
                    cnt_hi <= hi_match ? '0 : cnt_hi + 1'b1;
                end
                MODE_T8_PWM8: begin
                    cnt_lo <= lo_match ? '0 : cnt_lo + 1'b1;
                    cnt_hi <= cnt_hi + 1'b1;
                end
                MODE_T16: begin
                    {cnt_hi, cnt_lo} <= full_match ? '0 : full_cnt + 1'b1;
                end
                MODE_PWMV: begin
                    {cnt_hi, cnt_lo} <= wide_wrap ? '0 : full_cnt + 1'b1;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/pwt_pwm.sv
module pwt_pwm
    import pwt_pkg::*;
#(
    parameter int SEC_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               duty_load,
    input  logic               running,
    input  mode_e              mode,
    input  logic [SEC_W-1:0]   val_lo,
    input  logic [SEC_W-1:0]   val_hi,
    input  logic [SEC_W-1:0]   cnt_lo,
    input  logic [SEC_W-1:0]   cnt_hi,
    output logic [2*SEC_W-1:0] duty_buf,
    output logic               pwm_out
);

    // Buffered duty: changes only on arm or at a period boundary
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         duty_buf <= '0;
        else if (duty_load) duty_buf <= {val_hi, val_lo};
    end

    always_comb begin
        pwm_out = 1'b0;
        if (running) begin
            unique case (mode)
                MODE_T8_PWM8: pwm_out = (cnt_hi < duty_buf[2*SEC_W-1:SEC_W]);
                MODE_PWMV:    pwm_out = ({cnt_hi, cnt_lo} < duty_buf);
                default:      pwm_out = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/pwm_timer_unit.sv
module pwm_timer_unit
    import pwt_pkg::*;
#(
    parameter int SEC_W  = 8,
    parameter int WSEL_W = 3,
    parameter int MIN_W  = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_tick,
    input  logic             half_tick,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [SEC_W-1:0] wr_data,
    output logic             pwm_out,
    output logic             irq_lo,
    output logic             irq_hi
);

    cfg_t               cfg, act_cfg;
    logic               run;
    logic [SEC_W-1:0]   val_lo, val_hi, cnt_lo, cnt_hi;
    logic               lo_evt, hi_evt, clr_cnt, arm, tick_en, duty_load;
    seq_state_e         state;
    logic [2*SEC_W-1:0] duty_buf;

    pwt_regs #(.SEC_W(SEC_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .lo_evt(lo_evt), .hi_evt(hi_evt), .cfg(cfg),
        .run(run), .val_lo(val_lo), .val_hi(val_hi),
        .irq_lo(irq_lo), .irq_hi(irq_hi)
    );

    pwt_seq seq_i (
        .clk(clk), .rst_n(rst_n), .run(run), .cfg(cfg),
        .cyc_tick(cyc_tick), .half_tick(half_tick), .state(state),
        .act_cfg(act_cfg), .clr_cnt(clr_cnt), .arm(arm), .tick_en(tick_en)
    );

    pwt_count #(.SEC_W(SEC_W), .WSEL_W(WSEL_W), .MIN_W(MIN_W)) count_i (
        .clk(clk), .rst_n(rst_n), .clr(clr_cnt), .tick_en(tick_en),
        .mode(act_cfg.mode), .wsel(act_cfg.wsel[WSEL_W-1:0]),
        .val_lo(val_lo), .val_hi(val_hi), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi),
        .lo_evt(lo_evt), .hi_evt(hi_evt)
    );

    assign duty_load = arm || hi_evt;

    pwt_pwm #(.SEC_W(SEC_W)) pwm_i (
        .clk(clk), .rst_n(rst_n), .duty_load(duty_load),
        .running(state == ST_RUN), .mode(act_cfg.mode),
        .val_lo(val_lo), .val_hi(val_hi), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi),
        .duty_buf(duty_buf), .pwm_out(pwm_out)
    );

endmodule

// File: rtl/pwt_chk.sv
module pwt_chk
    import pwt_pkg::*;
#(
    parameter int SEC_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input seq_state_e         state,
    input mode_e              mode,
    input logic [2*SEC_W-1:0] duty_buf,
    input logic               duty_load,
    input logic               pwm_out,
    input logic               hi_evt,
    input logic               irq_hi,
    input logic [SEC_W-1:0]   cnt_lo,
    input logic [SEC_W-1:0]   cnt_hi
);

    // R9
    timer_mode_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_DUAL8 || mode == MODE_T16) |-> !pwm_out);

    // R9
    halt_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_RUN) |-> !pwm_out);

    // R9
    zero_duty_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_buf == '0) |-> !pwm_out);

    // R8
    duty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(duty_buf) |-> $past(duty_load));

    // R10
    arm_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARM) |=> (cnt_lo == '0 && cnt_hi == '0));

    // R11
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hi_evt |=> irq_hi);

endmodule

bind pwm_timer_unit pwt_chk #(.SEC_W(SEC_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .state(state), .mode(act_cfg.mode),
    .duty_buf(duty_buf), .duty_load(duty_load), .pwm_out(pwm_out),
    .hi_evt(hi_evt), .irq_hi(irq_hi), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi)
);

// File: tb/pwm_timer_unit_tb_top.sv
module pwm_timer_unit_tb_top;

    typedef struct packed {
        logic [1:0]  mode;
        logic        fine;
        logic [2:0]  wsel;
        logic        half;
        logic [7:0]  lo;
        logic [7:0]  hi;
        logic [15:0] exp_lo;
        logic [15:0] exp_hi;
    } vec_t;

    localparam int NVEC  = 9;
    localparam int LIMIT = 1100;

    // exp value 0 means the flag must not rise within LIMIT ticks
    localparam vec_t VECS [NVEC] = '{
        '{2'd0, 1'b0, 3'd0, 1'b0, 8'd3,   8'd9,   16'd4, 16'd10},
        '{2'd0, 1'b0, 3'd0, 1'b0, 8'd0,   8'd255, 16'd1, 16'd256},
        '{2'd1, 1'b0, 3'd0, 1'b0, 8'd5,   8'd80,  16'd6, 16'd256},
        '{2'd2, 1'b0, 3'd0, 1'b0, 8'h2C,  8'h01,  16'd0, 16'd301},
        '{2'd2, 1'b1, 3'd0, 1'b1, 8'h10,  8'h00,  16'd0, 16'd17},   // R7 fine tick
        '{2'd2, 1'b0, 3'd0, 1'b1, 8'd4,   8'd0,   16'd0, 16'd0},    // R7 half ignored
        '{2'd3, 1'b0, 3'd0, 1'b0, 8'd0,   8'h80,  16'd0, 16'd512},
        '{2'd3, 1'b1, 3'd1, 1'b1, 8'd0,   8'd0,   16'd0, 16'd1024},
        '{2'd0, 1'b1, 3'd0, 1'b1, 8'd2,   8'd2,   16'd0, 16'd0}     // R7 narrow mode
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_tick = 1'b0;
    logic       half_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       pwm_out, irq_lo, irq_hi;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    pwm_timer_unit dut_i (
        .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .half_tick(half_tick),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pwm_out(pwm_out), .irq_lo(irq_lo), .irq_hi(irq_hi)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic do_tick(input logic h);
        @(negedge clk);
        if (h) half_tick = 1'b1; else cyc_tick = 1'b1;
        @(negedge clk);
        half_tick = 1'b0; cyc_tick = 1'b0;
    endtask

    task automatic measure(input int n, output int highs);
        highs = 0;
        for (int i = 0; i < n; i++) begin
            if (pwm_out) highs++;
            do_tick(1'b0);
        end
    endtask

    function automatic string vtag(input logic [1:0] m);
        case (m)
            2'd0:    return "R3";
            2'd1:    return "R4";
            2'd2:    return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic run_tests();
        int highs;
        int t;
        // R1: reset state
        check("R1", int'(pwm_out), 0);
        check("R1", int'(irq_lo), 0);
        check("R1", int'(irq_hi), 0);

        for (int v = 0; v < NVEC; v++) begin
            int got_lo;
            int got_hi;
            got_lo = 0; got_hi = 0;
            wr(2'd0, 8'h00);
            wr(2'd3, 8'h03);
            wr(2'd1, VECS[v].lo);
            wr(2'd2, VECS[v].hi);
            wr(2'd0, {2'b01, VECS[v].wsel, VECS[v].fine, VECS[v].mode});
            settle();
            for (int k = 1; k <= LIMIT; k++) begin
                do_tick(VECS[v].half);
                if (got_lo == 0 && irq_lo) got_lo = k;
                if (got_hi == 0 && irq_hi) got_hi = k;
                if (got_lo != 0 && got_hi != 0) break;
            end
            check(vtag(VECS[v].mode), got_lo, int'(VECS[v].exp_lo));
            check(vtag(VECS[v].mode), got_hi, int'(VECS[v].exp_hi));
        end

        // R4 / R8 / R9: 8-bit PWM duty and buffering
        wr(2'd0, 8'h00);
        wr(2'd2, 8'd64);
        wr(2'd0, 8'h41);
        settle();
        measure(256, highs);
        check("R4", highs, 64);
        measure(10, highs);
        check("R8", highs, 10);
        wr(2'd2, 8'd200);
        measure(246, highs);
        check("R8", highs, 54);
        measure(256, highs);
        check("R8", highs, 200);
        wr(2'd2, 8'd0);
        measure(256, highs);
        measure(256, highs);
        check("R9", highs, 0);

        // R6: wide PWM, N = 9
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h00);
        wr(2'd2, 8'h01);
        wr(2'd0, 8'h43);
        settle();
        measure(512, highs);
        check("R6", highs, 256);
        wr(2'd1, 8'hFF);
        wr(2'd2, 8'hFF);
        measure(512, highs);
        measure(512, highs);
        check("R6", highs, 512);
        check("R6", int'(pwm_out), 1);
        wr(2'd0, 8'h03);
        settle();
        check("R10", int'(pwm_out), 0);

        // R10: configuration change while running restarts counting
        wr(2'd3, 8'h03);
        wr(2'd1, 8'd3);
        wr(2'd0, 8'h40);
        settle();
        do_tick(1'b0);
        do_tick(1'b0);
        wr(2'd0, 8'h48);
        settle();
        t = 0;
        for (int k = 1; k <= 20; k++) begin
            do_tick(1'b0);
            if (irq_lo) begin t = k; break; end
        end
        check("R10", t, 4);

        // R11: flag is sticky, then cleared by write (R2)
        do_tick(1'b0);
        check("R11", int'(irq_lo), 1);
        wr(2'd3, 8'h01);
        check("R2", int'(irq_lo), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        fork
            run_tests();
            begin
                repeat (190000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule